// File: doc/BRIEF.md
# NAND Two-Phase Access Sequencer

This block converts single memory-mapped requests into NAND flash bus cycles. Each request carries a 32-bit address and, for writes, 32 bits of data. The address does more than locate data: its fields choose a command phase or a data phase, give the commands and the number of address bytes, and say how the phase should end. One request moves one command/address sequence or one 32-bit data word, so a host runs a whole NAND operation as a series of requests.

A command phase sends a start command, then zero to four address bytes taken from the request data, then an optional end command. A data phase moves one 32-bit word as bus beats of 8 or 16 bits, writing or reading. It can follow the data with an end command and then wait for the flash ready/busy line to signal that the operation has finished. On its final transfer a data phase can also release chip enable. The widths of the WE_n and RE_n low and high pulses are counts in clock cycles. A busy flag holds off new requests while a sequence runs.

Top module: `nand_phase_seq`

## Requirements
- R1: After reset all chip enables are high, WE_n and RE_n are high, CLE and ALE are low, busy is low and the data bus is not driven.
- R2: A request with address bit 19 clear is a command phase. Its first bus cycle is a write strobe with CLE high that carries the start command, address bits 10:3.
- R3: A command phase then issues address bits 23:21 address bytes, each a write strobe with ALE high. They come from the request write data, least significant byte first. A count above 4 is treated as 4.
- R4: When address bit 20 is set, the last bus cycle of the request is a write strobe with CLE high carrying the end command, address bits 18:11. When bit 20 is clear, no end command is sent.
- R5: A data-phase write (bit 19 set, write request) drives 32/DW write strobes with CLE and ALE low, lowest beat of the write data first.
- R6: A data-phase read drives 32/DW read strobes. It packs the sampled bus values into the read data lowest beat first and pulses the read-valid output in the first cycle that busy is low again.
- R7: Chip enable n is low exactly when the chip number in address bits 31:24 equals n; a chip number of NCS or more selects none. Chip enable stays asserted through every bus cycle and after the request, unless the request is a data phase with address bit 21 set, in which case all chip enables go high once the request completes.
- R8: In a data phase with an end command, busy stays high after the end command until the ready/busy input has gone low and then returned high.
- R9: Every WE_n or RE_n low pulse lasts the programmed low count in clock cycles, and a count of 0 acts as 1.
- R10: A request presented while busy is high is ignored and causes no bus cycle.
- R11: CLE and ALE are never both high, and WE_n and RE_n are never both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present; taken when busy is low |
| req_write_i | input | 1 | 1 = write request, 0 = read request |
| req_addr_i | input | 32 | Request address with the phase control fields |
| req_wdata_i | input | 32 | Write data, or the address bytes of a command phase |
| busy_o | output | 1 | Sequence in progress |
| rdata_o | output | 32 | Data assembled by a data-phase read |
| rdata_valid_o | output | 1 | One-cycle pulse when rdata_o is updated |
| we_low_i | input | TW | WE_n low width in cycles |
| we_high_i | input | TW | WE_n high width in cycles |
| re_low_i | input | TW | RE_n low width in cycles |
| re_high_i | input | TW | RE_n high width in cycles |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| ce_no | output | NCS | Chip enables, active low |
| we_no | output | 1 | Write strobe, active low |
| re_no | output | 1 | Read strobe, active low |
| dq_o | output | DW | Flash data bus out |
| dq_oe_o | output | 1 | Data bus output enable |
| dq_i | input | DW | Flash data bus in |
| rb_ni | input | 1 | Ready/busy from flash, low while busy |

## Verification
If the phase state or beat index goes wrong, the bus-cycle log shows it on the next strobe edge: a byte out of order, a missing or extra CLE or ALE cycle, or a read word packed in the wrong order. A wrong strobe counter shows up at once as a pulse of the wrong length. A chip-select error is caught at every logged bus cycle and again after each request. Any leak in the ready/busy wait appears in the first cycle that busy drops while the ready/busy input is still low.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CSTART, ST_ADDR, ST_DATA, ST_END, ST_WLOW, ST_WHIGH
  } seq_state_e;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} strobe_ph_e;

  typedef struct packed {
    logic [7:0] chip;
    logic       data_ph;
    logic [7:0] start_cmd;
    logic [7:0] end_cmd;
    logic       end_vld;
    logic [2:0] naddr;
    logic       clr_cs;
  } req_fields_t;

endpackage

// File: rtl/nand_req_decode.sv
module nand_req_decode
  import nand_seq_pkg::*;
(
  input  logic [31:0] addr_i,
  output req_fields_t f_o
);
  localparam logic [2:0] MAX_ADDR = 3'd4;

  always_comb begin
    f_o.chip      = addr_i[31:24];
    f_o.data_ph   = addr_i[19];
    f_o.end_vld   = addr_i[20];
    f_o.end_cmd   = addr_i[18:11];
    f_o.start_cmd = addr_i[10:3];
    f_o.clr_cs    = addr_i[19] & addr_i[21];
    // wdata holds only four bytes
    f_o.naddr     = (addr_i[23:21] > MAX_ADDR) ? MAX_ADDR : addr_i[23:21];
  end
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nand_seq_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [TW-1:0] low_i,
  input  logic [TW-1:0] high_i,
  output logic          strobe_no,
  output logic          sample_o,
  output logic          done_o,
  output logic          idle_o
);
  localparam logic [TW-1:0] ONE = TW'(1);

  strobe_ph_e    ph_q;
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] low_eff, high_eff;

  assign low_eff  = (low_i == '0) ? ONE : low_i;
  assign high_eff = (high_i == '0) ? ONE : high_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q  <= PH_LOW;
          cnt_q <= low_eff;
        end
        PH_LOW: if (cnt_q == ONE) begin
          ph_q  <= PH_HIGH;
          cnt_q <= high_eff;
        end else cnt_q <= cnt_q - ONE;
        PH_HIGH: if (cnt_q == ONE) ph_q <= PH_IDLE;
                 else cnt_q <= cnt_q - ONE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign strobe_no = (ph_q != PH_LOW);
  assign sample_o  = (ph_q == PH_LOW) && (cnt_q == ONE);
  assign done_o    = (ph_q == PH_HIGH) && (cnt_q == ONE);
  assign idle_o    = (ph_q == PH_IDLE);

  // R9: the strobe only rises after the sampling cycle closes the low pulse
  a_r9_sample_then_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_no) |-> $past(sample_o));
endmodule

// File: rtl/nand_cs_ctrl.sv
module nand_cs_ctrl #(
  parameter int NCS = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           release_i,
  input  logic [7:0]     chip_i,
  output logic [NCS-1:0] ce_no
);
  for (genvar g = 0; g < NCS; g++) begin : g_cs
    logic sel_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        sel_q <= 1'b0;
      else if (load_i)    sel_q <= (chip_i == 8'(g));
      else if (release_i) sel_q <= 1'b0;
    end
    assign ce_no[g] = ~sel_q;
  end

  a_r7_ce_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ce_no));
endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_seq_pkg::*;
#(
  parameter int DW  = 8,
  parameter int NCS = 4,
  parameter int TW  = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  input  logic           req_write_i,
  input  logic [31:0]    req_addr_i,
  input  logic [31:0]    req_wdata_i,
  output logic           busy_o,
  output logic [31:0]    rdata_o,
  output logic           rdata_valid_o,
  input  logic [TW-1:0]  we_low_i,
  input  logic [TW-1:0]  we_high_i,
  input  logic [TW-1:0]  re_low_i,
  input  logic [TW-1:0]  re_high_i,
  output logic           cle_o,
  output logic           ale_o,
  output logic [NCS-1:0] ce_no,
  output logic           we_no,
  output logic           re_no,
  output logic [DW-1:0]  dq_o,
  output logic           dq_oe_o,
  input  logic [DW-1:0]  dq_i,
  input  logic           rb_ni
);
  localparam int BEATS = 32 / DW;
  localparam int IW    = 3;
  localparam logic [IW-1:0] LAST_BEAT = IW'(BEATS - 1);

  seq_state_e  st_q, st_d;
  req_fields_t dec, req_q;
  logic [31:0] wdata_q, rdata_q;
  logic        wr_q, rvld_q;
  logic [IW-1:0] idx_q, idx_d;
  logic        fin, accept, use_re, unit_st;
  logic        g_start, g_strobe_n, g_sample, g_done, g_idle;

  nand_req_decode u_dec (.addr_i(req_addr_i), .f_o(dec));

  assign accept  = (st_q == ST_IDLE) && req_valid_i;
  assign unit_st = (st_q == ST_CSTART) || (st_q == ST_ADDR) ||
                   (st_q == ST_DATA) || (st_q == ST_END);
  assign use_re  = (st_q == ST_DATA) && !wr_q;
  assign g_start = unit_st && g_idle;

  nand_strobe_gen #(.TW(TW)) u_stb (
    .clk_i, .rst_ni,
    .start_i  (g_start),
    .low_i    (use_re ? re_low_i  : we_low_i),
    .high_i   (use_re ? re_high_i : we_high_i),
    .strobe_no(g_strobe_n),
    .sample_o (g_sample),
    .done_o   (g_done),
    .idle_o   (g_idle)
  );

  nand_cs_ctrl #(.NCS(NCS)) u_cs (
    .clk_i, .rst_ni,
    .load_i   (accept),
    .release_i(fin && req_q.clr_cs),
    .chip_i   (dec.chip),
    .ce_no    (ce_no)
  );

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    fin   = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid_i) begin
        st_d  = dec.data_ph ? ST_DATA : ST_CSTART;
        idx_d = '0;
      end
      ST_CSTART: if (g_done) begin
        if (req_q.naddr != '0) st_d = ST_ADDR;
        else if (req_q.end_vld) st_d = ST_END;
        else fin = 1'b1;
      end
      ST_ADDR: if (g_done) begin
        if (idx_q == req_q.naddr - 3'd1) begin
          if (req_q.end_vld) st_d = ST_END;
          else fin = 1'b1;
        end else idx_d = idx_q + 1'b1;
      end
      ST_DATA: if (g_done) begin
        if (idx_q == LAST_BEAT) begin
          if (req_q.end_vld) st_d = ST_END;
          else fin = 1'b1;
        end else idx_d = idx_q + 1'b1;
      end
      ST_END: if (g_done) begin
        if (req_q.data_ph) st_d = ST_WLOW;
        else fin = 1'b1;
      end
      ST_WLOW:  if (!rb_ni) st_d = ST_WHIGH;
      ST_WHIGH: if (rb_ni) fin = 1'b1;
      default:  st_d = ST_IDLE;
    endcase
    if (fin) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      req_q   <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rdata_q <= '0;
      rvld_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      rvld_q <= fin && req_q.data_ph && !wr_q;
      if (accept) begin
        req_q   <= dec;
        wdata_q <= req_wdata_i;
        wr_q    <= req_write_i;
      end
      if (use_re && g_sample) rdata_q[int'(idx_q)*DW +: DW] <= dq_i;
    end
  end

  always_comb begin
    dq_o = '0;
    case (st_q)
      ST_CSTART: dq_o = DW'(req_q.start_cmd);
      ST_ADDR:   dq_o = DW'(wdata_q[int'(idx_q)*8 +: 8]);
      ST_END:    dq_o = DW'(req_q.end_cmd);
      ST_DATA:   dq_o = wdata_q[int'(idx_q)*DW +: DW];
      default:   dq_o = '0;
    endcase
  end

  assign cle_o         = (st_q == ST_CSTART) || (st_q == ST_END);
  assign ale_o         = (st_q == ST_ADDR);
  assign we_no         = use_re ? 1'b1 : g_strobe_n;
  assign re_no         = use_re ? g_strobe_n : 1'b1;
  assign dq_oe_o       = unit_st && !use_re;
  assign busy_o        = (st_q != ST_IDLE);
  assign rdata_o       = rdata_q;
  assign rdata_valid_o = rvld_q;

  // R8: no completion while the flash still reports busy
  a_r8_wait_rb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WHIGH && !rb_ni) |=> (st_q == ST_WHIGH));
  // R10: a latched request is not overwritten while busy
  a_r10_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(req_q) && $stable(wdata_q)));
  // R7: chip enables do not move during data beats
  a_r7_ce_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA && $past(st_q) == ST_DATA) |-> $stable(ce_no));
  // R6: read-valid only appears with the sequencer idle
  a_r6_rvalid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> !busy_o);
  // R11: strobes are never both low
  a_r11_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));
endmodule

// File: tb/nand_phase_seq_bench.sv
module nand_phase_seq_bench;
  localparam int DW = 8, NCS = 4, TW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni, req_valid, req_write, busy, rdata_valid;
  logic [31:0] req_addr, req_wdata, rdata;
  logic [TW-1:0] wl, wh, rl, rh;
  logic cle, ale, we_n, re_n, dq_oe;
  logic [NCS-1:0] ce_n;
  logic [DW-1:0] dq_o, dq_i;
  logic rb_q = 1'b1;

  int n_chk = 0, n_bad = 0;
  int lg_kind[1024];
  logic [7:0] lg_val[1024];
  logic [3:0] lg_ce[1024];
  int lg_w[1024];
  int lg_n = 0, rd_total = 0, we_lo = 0, re_lo = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;
  int rb_dly = 0, rb_len = 0, rb_viol = 0, rb_low_seen = 0;
  bit trk = 0;

  assign dq_i = 8'(rd_total) ^ 8'h5A;

  nand_phase_seq #(.DW(DW), .NCS(NCS), .TW(TW)) u_nand_phase_seq (
    .clk_i(clk), .rst_ni, .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .busy_o(busy),
    .rdata_o(rdata), .rdata_valid_o(rdata_valid),
    .we_low_i(wl), .we_high_i(wh), .re_low_i(rl), .re_high_i(rh),
    .cle_o(cle), .ale_o(ale), .ce_no(ce_n), .we_no(we_n), .re_no(re_n),
    .dq_o, .dq_oe_o(dq_oe), .dq_i, .rb_ni(rb_q));

  // flash-side monitor and ready/busy model
  always @(negedge clk) begin
    prev_we <= we_n;
    prev_re <= re_n;
    if (!we_n) we_lo <= we_lo + 1;
    if (!re_n) re_lo <= re_lo + 1;
    if (trk && !rb_q && !busy) rb_viol <= rb_viol + 1;
    if (trk && !rb_q) rb_low_seen <= rb_low_seen + 1;
    if (prev_we == 1'b0 && we_n == 1'b1) begin
      lg_kind[lg_n] <= (cle && ale) ? 4 : cle ? 0 : ale ? 1 : 2;
      lg_val[lg_n]  <= dq_o;
      lg_ce[lg_n]   <= ce_n;
      lg_w[lg_n]    <= we_lo;
      lg_n          <= lg_n + 1;
      we_lo         <= 0;
    end else if (prev_re == 1'b0 && re_n == 1'b1) begin
      lg_kind[lg_n] <= 3;
      lg_val[lg_n]  <= dq_i;
      lg_ce[lg_n]   <= ce_n;
      lg_w[lg_n]    <= re_lo;
      lg_n          <= lg_n + 1;
      rd_total      <= rd_total + 1;
      re_lo         <= 0;
    end
    if (prev_we == 1'b0 && we_n == 1'b1 && cle) rb_dly <= 3;
    else if (rb_dly != 0) begin
      rb_dly <= rb_dly - 1;
      if (rb_dly == 1) begin rb_q <= 1'b0; rb_len <= 6; end
    end else if (rb_len != 0) begin
      rb_len <= rb_len - 1;
      if (rb_len == 1) rb_q <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int eff(input logic [TW-1:0] x);
    return (x == 0) ? 1 : int'(x);
  endfunction

  function automatic logic [3:0] exp_ce(input logic [7:0] chip);
    return (chip < NCS) ? ~(4'b1 << chip) : 4'hF;
  endfunction

  function automatic logic [31:0] mk_cmd(input logic [7:0] chip, input logic [2:0] na,
                                         input logic ev, input logic [7:0] ec, sc);
    return {chip, na, ev, 1'b0, ec, sc, 3'b000};
  endfunction

  function automatic logic [31:0] mk_data(input logic [7:0] chip, input logic clr,
                                          input logic ev, input logic [7:0] ec);
    return {chip, 2'b00, clr, ev, 1'b1, ec, 8'h00, 3'b000};
  endfunction

  task automatic run_req(input logic [31:0] a, input logic [31:0] w,
                         input logic wr, input bit poke);
    int ek[8];
    logic [7:0] ev[8];
    string et[8];
    int en = 0, base, rbase, na;
    logic [31:0] exp_rd = '0;
    bit data = a[19];
    bit endv = a[20];
    while (rb_dly != 0 || rb_len != 0 || !rb_q) @(negedge clk);
    base = lg_n; rbase = rd_total;
    if (!data) begin
      ek[en] = 0; ev[en] = a[10:3]; et[en] = "R2"; en++;
      na = (a[23:21] > 4) ? 4 : int'(a[23:21]);
      for (int k = 0; k < na; k++) begin
        ek[en] = 1; ev[en] = w[8*k +: 8]; et[en] = "R3"; en++;
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (wr) begin ek[en] = 2; ev[en] = w[8*k +: 8]; et[en] = "R5"; end
        else begin
          ek[en] = 3; ev[en] = 8'(rbase + k) ^ 8'h5A; et[en] = "R6";
          exp_rd[8*k +: 8] = ev[en];
        end
        en++;
      end
    end
    if (endv) begin ek[en] = 0; ev[en] = a[18:11]; et[en] = "R4"; en++; end
    rb_viol = 0; rb_low_seen = 0;
    trk = data && endv;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_wdata = w; req_write = wr;
    @(negedge clk);
    if (poke) begin
      req_addr = ~a; req_wdata = ~w; req_write = ~wr;
      repeat (3) @(negedge clk);
    end
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    trk = 0;
    chk(lg_n - base == en, data ? "R5" : "R3", "bus cycle count", lg_n - base, en);
    for (int i = 0; i < en && i < lg_n - base; i++) begin
      chk(lg_kind[base+i] == ek[i], et[i], "cycle kind", lg_kind[base+i], ek[i]);
      chk(lg_val[base+i] == ev[i], et[i], "cycle byte", lg_val[base+i], ev[i]);
      chk(lg_ce[base+i] == exp_ce(a[31:24]), "R7", "ce during cycle",
          lg_ce[base+i], exp_ce(a[31:24]));
      chk(lg_w[base+i] == (ek[i] == 3 ? eff(rl) : eff(wl)), "R9", "low width",
          lg_w[base+i], ek[i] == 3 ? eff(rl) : eff(wl));
    end
    chk(ce_n == ((data && a[21]) ? 4'hF : exp_ce(a[31:24])), "R7", "ce after",
        ce_n, (data && a[21]) ? 4'hF : exp_ce(a[31:24]));
    if (data && !wr) begin
      chk(rdata_valid == 1'b1, "R6", "read valid", rdata_valid, 1);
      chk(rdata == exp_rd, "R6", "read word", rdata, exp_rd);
    end
    if (data && endv) begin
      chk(rb_viol == 0, "R8", "busy dropped during flash busy", rb_viol, 0);
      chk(rb_low_seen > 0, "R8", "flash busy observed", rb_low_seen, 1);
    end
    if (poke) begin
      repeat (10) @(negedge clk);
      chk(lg_n == base + en && !busy, "R10", "request while busy ran", lg_n - base, en);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] a, w;
    rst_ni = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    wl = 4'd2; wh = 4'd1; rl = 4'd3; rh = 4'd2;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(ce_n == 4'hF, "R1", "ce", ce_n, 4'hF);
    chk(we_n && re_n, "R1", "strobes", {we_n, re_n}, 2'b11);
    chk(!cle && !ale && !dq_oe, "R1", "cle/ale/oe", {cle, ale, dq_oe}, 0);
    chk(!busy, "R1", "busy", busy, 0);

    // directed corners
    run_req(mk_cmd(8'd1, 3'd5, 1'b1, 8'h30, 8'h00), 32'hA4B3C2D1, 1'b1, 0); // R3 clamp
    run_req(mk_data(8'd1, 1'b0, 1'b0, 8'h00), 32'h0, 1'b0, 0);              // R6
    run_req(mk_data(8'd1, 1'b1, 1'b0, 8'h00), 32'h11223344, 1'b1, 0);       // R7 release
    wl = 0; wh = 0; rl = 0; rh = 0;                                         // R9 zero
    run_req(mk_cmd(8'd2, 3'd3, 1'b1, 8'h10, 8'h80), 32'h00CAFE77, 1'b1, 1); // R10
    run_req(mk_data(8'd2, 1'b1, 1'b1, 8'h70), 32'h0, 1'b0, 0);              // R8
    run_req(mk_cmd(8'd5, 3'd0, 1'b0, 8'h00, 8'hFF), 32'h0, 1'b1, 0);        // R7 none
    run_req(mk_data(8'd3, 1'b0, 1'b1, 8'h10), 32'hDEADBEEF, 1'b1, 0);       // R4,R8

    for (int n = 0; n < 60; n++) begin
      wl = TW'($urandom_range(0, 3)); wh = TW'($urandom_range(0, 3));
      rl = TW'($urandom_range(0, 3)); rh = TW'($urandom_range(0, 3));
      w = $urandom;
      if ($urandom_range(0, 1) == 0)
        a = mk_cmd(8'($urandom_range(0, 5)), 3'($urandom_range(0, 7)),
                   1'($urandom_range(0, 1)), 8'($urandom), 8'($urandom));
      else
        a = mk_data(8'($urandom_range(0, 5)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), 8'($urandom));
      run_req(a, w, 1'($urandom_range(0, 1)), 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule